// File: doc/BRIEF.md
# Three-wire RF register master

This block drives the serial control port of a radio front end. The port has an active-low enable, a serial clock, a data line and a read/write indicator. The data line is split into an output, an output enable and an input, and the pad logic outside the block combines them. A host writes a register by presenting a 4-bit address and 12 bits of data. It reads a register by presenting a 5-bit address, and 12 bits come back.

All timing on the port is counted in ticks. One tick lasts `tick_div + 1` clock cycles, and the block takes `tick_div` when it accepts a request. Each frame starts with a short enable-high guard and then a longer enable-low lead. The bits follow, and a final enable-high tail ends the frame. In a write, all 16 frame bits leave most significant bit first. In a read, only the address goes out. The block then raises the read/write indicator, releases the data line and clocks in 12 bits from the slave, most significant bit first.

The block accepts one request at a time. `busy` covers the whole frame, including its tail. `done` pulses once when the frame finishes. After a read, the result stays on `rd_data` until the next read finishes.

Top module: `rf3w_master`

## Requirements
- R1: While reset is high, and after it is released with no request, the port is idle. Enable is high (1), the clock is low, read/write is low and the data output is 0 with its enable at 1. `busy`, `done` and `rd_data` are all 0.
- R2: A write frame is 16 bits, with the data in bits [15:4] and the address in bits [3:0]. It is sent bit 15 first. Each bit is placed on the data output for one tick with the clock low, then held for one tick with the clock high.
- R3: Every frame begins with PRE_TICKS ticks of enable high, then LEAD_TICKS ticks of enable low with the clock low. After the last bit of a write, enable is high with the clock low for TAIL_TICKS ticks.
- R4: A read sends exactly 5 address bits, most significant bit first, with the bit timing of R2. Read/write stays low (0) throughout and the data output stays enabled.
- R5: After the fifth address bit there is one turnaround tick. In it, read/write goes to 1 (read) and the data output enable goes to 0. Both hold for all 12 read bits.
- R6: Each of the 12 read bits takes one tick with the clock low, then SAMPLE_TICKS ticks with the clock high. The input is captured in the last clock cycle of the high phase. The first bit captured becomes bit 11 of the result.
- R7: A read ends with one tick of enable high while read/write is still 1. Then read/write returns to 0 and the data output enable returns to 1 for TAIL_TICKS ticks, with enable high.
- R8: The tick length is `tick_div + 1` cycles, taken at acceptance. Changing `tick_div` during a frame does not alter that frame.
- R9: `busy` rises in the cycle after a request is accepted and falls when the tail ends. Requests presented while busy are ignored.
- R10: `done` is high for exactly one cycle, the first cycle with `busy` low. A read's result appears on `rd_data` in that cycle. `rd_data` changes at no other time, and writes leave it unchanged.
- R11: If a write request and a read request arrive in the same idle cycle, the write is performed and the read is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div | input | DIV_W | Tick length minus one, in clock cycles |
| wr_req | input | 1 | Write request, taken when idle |
| wr_addr | input | WA_W | Write register address |
| wr_data | input | D_W | Write data |
| rd_req | input | 1 | Read request, taken when idle |
| rd_addr | input | RA_W | Read register address |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | D_W | Result of the last completed read |
| rf_en_n | output | 1 | Port enable, active low |
| rf_clk | output | 1 | Serial clock |
| rf_rw | output | 1 | Read/write indicator, 1 during the read phase |
| rf_sdo | output | 1 | Data line output value |
| rf_sdo_en | output | 1 | Data line output enable |
| rf_sdi | input | 1 | Data line input from the slave |

## Verification
The bench builds the block with shorter lead and tail lengths (6 and 4 ticks), a guard of 2 ticks, a 3-tick sample phase and a 4-bit divider input. The shorter frames let many reads and writes fit in one short run. It drives `tick_div` at 0, 1, 2 and 3. A value of 0 makes every cycle a tick, where any off-by-one in segment length shows at once. The larger values test the latching of the divider, because `tick_div` changes in the middle of a frame. A slave model captures write frames into a 32-entry register file and answers reads from it, including addresses 16 to 31, which no write can reach.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_LEAD,
        ST_BLO,
        ST_BHI,
        ST_TURN,
        ST_RLO,
        ST_RHI,
        ST_REND,
        ST_TAIL
    } rf3w_state_e;

    typedef struct packed {
        logic en_n;
        logic sclk;
        logic rw;
        logic sdo_en;
        logic sdo;
    } rf3w_pins_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Pin levels for each sequencer state; bitv is the outgoing serial bit.
    function automatic rf3w_pins_t pins_of(input rf3w_state_e st, input logic bitv);
        rf3w_pins_t p;
        p.en_n   = 1'b1;
        p.sclk   = 1'b0;
        p.rw     = 1'b0;
        p.sdo_en = 1'b1;
        p.sdo    = 1'b0;
        case (st)
            ST_LEAD: p.en_n = 1'b0;
            ST_BLO: begin
                p.en_n = 1'b0;
                p.sdo  = bitv;
            end
            ST_BHI: begin
                p.en_n = 1'b0;
                p.sclk = 1'b1;
                p.sdo  = bitv;
            end
            ST_TURN, ST_RLO: begin
                p.en_n   = 1'b0;
                p.rw     = 1'b1;
                p.sdo_en = 1'b0;
            end
            ST_RHI: begin
                p.en_n   = 1'b0;
                p.sclk   = 1'b1;
                p.rw     = 1'b1;
                p.sdo_en = 1'b0;
            end
            ST_REND: begin
                p.rw     = 1'b1;
                p.sdo_en = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rf3w_tick.sv
module rf3w_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (restart) begin
            div_q <= div_in;
            cnt_q <= '0;
        end else if (cnt_q == div_q) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    assign tick = (cnt_q == div_q);

    // R8
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && div_q != '0) |=> !tick);

endmodule

// File: rtl/rf3w_seq.sv
module rf3w_seq
    import rf3w_pkg::*;
#(
    parameter int WA_W         = 4,
    parameter int RA_W         = 5,
    parameter int D_W          = 12,
    parameter int PRE_TICKS    = 2,
    parameter int LEAD_TICKS   = 10,
    parameter int TAIL_TICKS   = 10,
    parameter int SAMPLE_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_req,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [D_W-1:0]    wr_data,
    input  logic              rd_req,
    input  logic [RA_W-1:0]   rd_addr,
    input  logic              sdi,
    output logic              start,
    output rf3w_state_e       state,
    output logic              tx_bit,
    output logic              busy,
    output logic              done,
    output logic [D_W-1:0]    rd_data
);
    localparam int FW   = D_W + WA_W;
    localparam int PADW = FW - RA_W;
    localparam int MAXT = umax(umax(PRE_TICKS, LEAD_TICKS), umax(TAIL_TICKS, SAMPLE_TICKS));
    localparam int CW   = $clog2(MAXT) + 1;
    localparam int BW   = $clog2(umax(FW, D_W));

    rf3w_state_e  st_q;
    logic         is_rd_q;
    logic [CW-1:0] unit_q;
    logic [CW-1:0] seg_m1;
    logic [BW-1:0] idx_q;
    logic [BW-1:0] last_idx;
    logic [FW-1:0] tx_q;
    logic [D_W-1:0] cap_q;
    logic          seg_end;

    always_comb begin
        case (st_q)
            ST_PRE:  seg_m1 = CW'(PRE_TICKS - 1);
            ST_LEAD: seg_m1 = CW'(LEAD_TICKS - 1);
            ST_RHI:  seg_m1 = CW'(SAMPLE_TICKS - 1);
            ST_TAIL: seg_m1 = CW'(TAIL_TICKS - 1);
            default: seg_m1 = '0;
        endcase
    end

    assign start    = (st_q == ST_IDLE) && (wr_req || rd_req);
    assign seg_end  = tick && (unit_q == seg_m1);
    assign last_idx = is_rd_q ? BW'(RA_W - 1) : BW'(FW - 1);
    assign state    = st_q;
    assign tx_bit   = tx_q[FW-1];
    assign busy     = (st_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            is_rd_q <= 1'b0;
            unit_q  <= '0;
            idx_q   <= '0;
            tx_q    <= '0;
            cap_q   <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                st_q    <= ST_PRE;
                unit_q  <= '0;
                idx_q   <= '0;
                is_rd_q <= !wr_req;
                tx_q    <= wr_req ? {wr_data, wr_addr} : {rd_addr, {PADW{1'b0}}};
            end else if (tick && st_q != ST_IDLE) begin
                if (!seg_end) begin
                    unit_q <= unit_q + CW'(1);
                end else begin
                    unit_q <= '0;
                    case (st_q)
                        ST_PRE:  st_q <= ST_LEAD;
                        ST_LEAD: st_q <= ST_BLO;
                        ST_BLO:  st_q <= ST_BHI;
                        ST_BHI: begin
                            if (idx_q == last_idx) begin
                                idx_q <= '0;
                                st_q  <= is_rd_q ? ST_TURN : ST_TAIL;
                            end else begin
                                idx_q <= idx_q + BW'(1);
                                tx_q  <= {tx_q[FW-2:0], 1'b0};
                                st_q  <= ST_BLO;
                            end
                        end
                        ST_TURN: st_q <= ST_RLO;
                        ST_RLO:  st_q <= ST_RHI;
                        ST_RHI: begin
                            cap_q <= {cap_q[D_W-2:0], sdi};
                            if (idx_q == BW'(D_W - 1)) begin
                                idx_q <= '0;
                                st_q  <= ST_REND;
                            end else begin
                                idx_q <= idx_q + BW'(1);
                                st_q  <= ST_RLO;
                            end
                        end
                        ST_REND: st_q <= ST_TAIL;
                        ST_TAIL: begin
                            st_q <= ST_IDLE;
                            done <= 1'b1;
                            if (is_rd_q) rd_data <= cap_q;
                        end
                        default: st_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_req || rd_req));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(rd_data));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $fell(busy));

endmodule

// File: rtl/rf3w_master.sv
module rf3w_master
    import rf3w_pkg::*;
#(
    parameter int WA_W         = 4,
    parameter int RA_W         = 5,
    parameter int D_W          = 12,
    parameter int DIV_W        = 8,
    parameter int PRE_TICKS    = 2,
    parameter int LEAD_TICKS   = 10,
    parameter int TAIL_TICKS   = 10,
    parameter int SAMPLE_TICKS = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] tick_div,
    input  logic             wr_req,
    input  logic [WA_W-1:0]  wr_addr,
    input  logic [D_W-1:0]   wr_data,
    input  logic             rd_req,
    input  logic [RA_W-1:0]  rd_addr,
    output logic             busy,
    output logic             done,
    output logic [D_W-1:0]   rd_data,
    output logic             rf_en_n,
    output logic             rf_clk,
    output logic             rf_rw,
    output logic             rf_sdo,
    output logic             rf_sdo_en,
    input  logic             rf_sdi
);
    logic        tick;
    logic        start;
    logic        tx_bit;
    rf3w_state_e state;
    rf3w_pins_t  pins;

    rf3w_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (start),
        .div_in  (tick_div),
        .tick    (tick)
    );

    rf3w_seq #(
        .WA_W         (WA_W),
        .RA_W         (RA_W),
        .D_W          (D_W),
        .PRE_TICKS    (PRE_TICKS),
        .LEAD_TICKS   (LEAD_TICKS),
        .TAIL_TICKS   (TAIL_TICKS),
        .SAMPLE_TICKS (SAMPLE_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .wr_req  (wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .sdi     (rf_sdi),
        .start   (start),
        .state   (state),
        .tx_bit  (tx_bit),
        .busy    (busy),
        .done    (done),
        .rd_data (rd_data)
    );

    assign pins      = pins_of(state, tx_bit);
    assign rf_en_n   = pins.en_n;
    assign rf_clk    = pins.sclk;
    assign rf_rw     = pins.rw;
    assign rf_sdo    = pins.sdo;
    assign rf_sdo_en = pins.sdo_en;

    // R3
    clk_en_chk: assert property (@(posedge clk) disable iff (rst)
        rf_clk |-> !rf_en_n);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !rf_sdo_en |-> rf_rw);

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rf_clk |-> $stable(rf_sdo));

    // R4
    addr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (rf_clk && !rf_rw) |-> rf_sdo_en);

endmodule

// File: tb/sim_rf3w_master.sv
module sim_rf3w_master;
    localparam int CLK_PERIOD = 10;
    localparam int WA     = 4;
    localparam int RA     = 5;
    localparam int DW     = 12;
    localparam int DIVW   = 4;
    localparam int T_PRE  = 2;
    localparam int T_LEAD = 6;
    localparam int T_TAIL = 4;
    localparam int T_SMP  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [DIVW-1:0] tick_div = '0;
    logic            wr_req = 1'b0;
    logic [WA-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic            rd_req = 1'b0;
    logic [RA-1:0]   rd_addr = '0;
    logic            busy, done;
    logic [DW-1:0]   rd_data;
    logic            rf_en_n, rf_clk, rf_rw, rf_sdo, rf_sdo_en, rf_sdi;

    always #(CLK_PERIOD/2) clk = ~clk;

    rf3w_master #(
        .WA_W(WA), .RA_W(RA), .D_W(DW), .DIV_W(DIVW),
        .PRE_TICKS(T_PRE), .LEAD_TICKS(T_LEAD), .TAIL_TICKS(T_TAIL), .SAMPLE_TICKS(T_SMP)
    ) u0 (
        .clk(clk), .rst(rst), .tick_div(tick_div),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .busy(busy), .done(done), .rd_data(rd_data),
        .rf_en_n(rf_en_n), .rf_clk(rf_clk), .rf_rw(rf_rw),
        .rf_sdo(rf_sdo), .rf_sdo_en(rf_sdo_en), .rf_sdi(rf_sdi)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int cyc = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] init_val(input int i);
        return DW'((i * 145) ^ 32'h5A3);
    endfunction

    // ---------------- reference model: queue of pin segments ----------------
    typedef struct packed {
        logic en_n;
        logic sck;
        logic rw;
        logic oe;
        logic sdo;
        int   ticks;
    } seg_t;

    seg_t          sq[$];
    string         tq[$];
    seg_t          cur;
    string         ctag = "R1";
    int            left = 0;
    bit            act = 1'b0;
    bit            m_done = 1'b0;
    logic [DW-1:0] m_rd = '0;
    int            m_div = 1;
    bit            op_rd = 1'b0;
    int            op_a = 0;
    logic [DW-1:0] mmem [0:31];
    logic [DW-1:0] smem [0:31];

    initial begin
        for (int i = 0; i < 32; i++) begin
            mmem[i] = init_val(i);
            smem[i] = init_val(i);
        end
    end

    task automatic push(input logic en, input logic c, input logic w, input logic oe,
                        input logic d, input int t, input string tag);
        seg_t s;
        s.en_n = en; s.sck = c; s.rw = w; s.oe = oe; s.sdo = d; s.ticks = t;
        sq.push_back(s);
        tq.push_back(tag);
    endtask

    task automatic next_seg();
        cur  = sq.pop_front();
        ctag = tq.pop_front();
        left = cur.ticks * m_div;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            act = 1'b0; m_done = 1'b0; m_rd = '0;
            sq.delete(); tq.delete();
        end else begin
            m_done = 1'b0;
            if (act) begin
                left--;
                if (left == 0) begin
                    if (sq.size() > 0) next_seg();
                    else begin
                        act = 1'b0;
                        m_done = 1'b1;
                        ctag = "R1";
                        if (op_rd) m_rd = mmem[op_a];
                    end
                end
            end else if (wr_req) begin
                // write wins over a simultaneous read (R11)
                logic [15:0] fr;
                fr = {wr_data, wr_addr};
                m_div = int'(tick_div) + 1;
                op_rd = 1'b0;
                mmem[wr_addr] = wr_data;
                push(1, 0, 0, 1, 0, T_PRE, "R3");
                push(0, 0, 0, 1, 0, T_LEAD, "R3");
                for (int i = 15; i >= 0; i--) begin
                    push(0, 0, 0, 1, fr[i], 1, "R2");
                    push(0, 1, 0, 1, fr[i], 1, "R2");
                end
                push(1, 0, 0, 1, 0, T_TAIL, "R3");
                next_seg();
                act = 1'b1;
            end else if (rd_req) begin
                m_div = int'(tick_div) + 1;
                op_rd = 1'b1;
                op_a  = int'(rd_addr);
                push(1, 0, 0, 1, 0, T_PRE, "R3");
                push(0, 0, 0, 1, 0, T_LEAD, "R3");
                for (int i = RA - 1; i >= 0; i--) begin
                    push(0, 0, 0, 1, rd_addr[i], 1, "R4");
                    push(0, 1, 0, 1, rd_addr[i], 1, "R4");
                end
                push(0, 0, 1, 0, 0, 1, "R5");
                for (int j = 0; j < DW; j++) begin
                    push(0, 0, 1, 0, 0, 1, "R6");
                    push(0, 1, 1, 0, 0, T_SMP, "R6");
                end
                push(1, 0, 1, 0, 0, 1, "R7");
                push(1, 0, 0, 1, 0, T_TAIL, "R7");
                next_seg();
                act = 1'b1;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic [4:0] exp_pins, act_pins;
    always @(negedge clk) begin
        if (!rst && !finished) begin
            exp_pins = act ? {cur.en_n, cur.sck, cur.rw, cur.oe, cur.sdo} : 5'b10010;
            act_pins = {rf_en_n, rf_clk, rf_rw, rf_sdo_en, rf_sdo};
            chk(ctag, "pins{en_n,clk,rw,oe,sdo}", 32'(act_pins), 32'(exp_pins));
            chk("R9", "busy", 32'(busy), 32'(act));
            chk("R10", "done", 32'(done), 32'(m_done));
            chk("R10", "rd_data", 32'(rd_data), 32'(m_rd));
        end
    end

    // ---------------- slave model, sampled mid-cycle ----------------
    logic [15:0]   s_sh = '0;
    int            s_cnt = 0;
    logic [DW-1:0] s_val = '0;
    int            s_idx = DW - 1;
    logic          p_clk = 1'b0, p_en = 1'b1, p_rw = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rf_clk && !p_clk && !rf_en_n && !rf_rw) begin
                s_sh = {s_sh[14:0], rf_sdo};
                s_cnt++;
            end
            if (rf_rw && !p_rw) begin
                s_val = smem[s_sh[4:0]];
                s_idx = DW - 1;
            end else if (!rf_clk && p_clk && rf_rw && s_idx > 0) begin
                s_idx--;
            end
            if (rf_en_n && !p_en) begin
                if (s_cnt == 16) smem[s_sh[3:0]] = s_sh[15:4];
                s_cnt = 0;
            end
        end
        p_clk = rf_clk; p_en = rf_en_n; p_rw = rf_rw;
    end

    assign rf_sdi = rf_rw ? s_val[s_idx] : 1'b0;

    // ---------------- stimulus ----------------
    task automatic do_wr(input logic [WA-1:0] a, input logic [DW-1:0] d);
        wr_addr = a; wr_data = d; wr_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    task automatic do_rd(input logic [RA-1:0] a);
        rd_addr = a; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog busy_cycles act=%0d exp=<150000", cyc);
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle state under reset
        chk("R1", "reset port/status", {rf_en_n, rf_clk, rf_rw, rf_sdo, rf_sdo_en, busy, done},
            7'b1000100);
        chk("R1", "reset rd_data", 32'(rd_data), 32'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "idle after reset", {rf_en_n, rf_clk, rf_rw, rf_sdo_en, busy}, 5'b10010);

        // R2 R3: write at single-cycle ticks, then read it back (R4 R5 R6 R7)
        tick_div = 4'd0;
        do_wr(4'd3, 12'hA5C);
        wait_done();
        do_rd(5'd3);
        wait_done();
        chk("R6", "read back addr 3", 32'(rd_data), 32'hA5C);

        // R6: read an address only reachable by reads, slower ticks
        tick_div = 4'd2;
        do_rd(5'd20);
        wait_done();
        chk("R6", "read addr 20", 32'(rd_data), 32'(init_val(20)));

        // R8 R9: divider change and stray requests during a frame
        tick_div = 4'd1;
        do_wr(4'd15, 12'hFFF);
        repeat (10) @(negedge clk);
        tick_div = 4'd3;
        wr_addr = 4'd15; wr_data = 12'h000; wr_req = 1'b1; rd_req = 1'b1; rd_addr = 5'd1;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        wait_done();
        // R10: a write leaves rd_data alone
        chk("R10", "rd_data after write", 32'(rd_data), 32'(init_val(20)));
        do_rd(5'd15);
        wait_done();
        chk("R9", "busy request ignored, addr 15", 32'(rd_data), 32'hFFF);

        // R11: simultaneous write and read
        tick_div = 4'd0;
        wr_addr = 4'd7; wr_data = 12'h3C3; rd_addr = 5'd9; wr_req = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        wr_req = 1'b0; rd_req = 1'b0;
        wait_done();
        chk("R11", "rd_data not updated by dropped read", 32'(rd_data), 32'hFFF);
        // back-to-back: new request in the done cycle
        do_rd(5'd7);
        wait_done();
        chk("R11", "write won, addr 7", 32'(rd_data), 32'h3C3);
        do_wr(4'd0, 12'h001);
        wait_done();
        do_rd(5'd0);
        wait_done();
        chk("R2", "lowest bit only, addr 0", 32'(rd_data), 32'h001);
        do_rd(5'd31);
        wait_done();
        chk("R4", "read addr 31", 32'(rd_data), 32'(init_val(31)));

        repeat (5) @(negedge clk);
        summary();
    end

endmodule